// File: doc/BRIEF.md
# Multi-Channel DMA Configuration Register Bank

This block is the software-facing target of a multi-channel DMA controller. A simple 32-bit request/response port reaches a 256-byte window. The upper three bits of the byte offset choose a channel and the next three bits choose a register within it. For each channel the block holds a source address, a destination address, a byte count and an interrupt mask. It hands the addresses and count to that channel's transfer engine. It raises a one-cycle start pulse when the byte count is written. It raises a one-cycle abort pulse when the channel's write-only reset register is written.

Each channel is governed by a three-state controller. In `CH_IDLE` the channel accepts new settings. Transition *launch* (a count write) moves it to `CH_BUSY`. Transition *finish* (the engine's done pulse while busy) moves it to `CH_DONE`. In `CH_DONE` the count reads zero and the sticky completion flag drives the interrupt unless it is masked. Transition *acknowledge* (any write to the reset register, from any state) returns the channel to `CH_IDLE`, clears the count and emits the abort pulse. Software polls the count register to see whether a channel is still working. It clears an interrupt by writing the reset register.

Every request receives a response on the next cycle. Offsets that name no register, a channel that is not built, a misaligned offset and a read of the write-only register all return an error. Such accesses change nothing.

Top module: `mdma_regs`

## Requirements
- R1: Offset bits [7:5] select the channel. Offset bits [4:2] select the register: 0 source, 1 destination, 2 byte count, 3 reset (write-only), 4 interrupt mask. A request sampled at a clock edge gets `rsp_valid` high for exactly the following cycle.
- R2: Source, destination and byte count read back the last accepted write with bits [1:0] forced to zero. The interrupt mask reads back all 32 bits as written.
- R3: A count write in `CH_IDLE` puts that channel in `CH_BUSY`, drives the masked count on its `ch_len` slice and pulses its `ch_start` bit for one cycle, in the cycle after the request.
- R4: In `CH_BUSY` or `CH_DONE`, writes to source, destination and byte count are ignored. The read-back is unchanged and no start pulse follows.
- R5: A done pulse in `CH_BUSY` moves the channel to `CH_DONE`, and its count then reads zero. A done pulse in `CH_IDLE` or `CH_DONE` has no effect.
- R6: `irq[k]` is high exactly when channel k is in `CH_DONE` and its mask register is zero. A mask change takes effect on the next cycle.
- R7: A write of any value to the reset register pulses `ch_abort[k]` for one cycle in the next cycle. It returns the channel to `CH_IDLE`, clears the count and drops `irq[k]`, and it keeps source and destination. When it coincides with a done pulse, the reset wins.
- R8: The response carries `rsp_err`=1 and `rsp_rdata`=0 for any of these: offset bits [1:0] non-zero, a channel index of `NCH` or above, a register index of 5 to 7, or a read of the reset register. Such an access changes no state.
- R9: After reset every register reads zero, every channel is in `CH_IDLE`, and `irq`, `ch_start`, `ch_abort` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the 256-byte window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_rdata | output | 32 | Read data (zero on writes and errors) |
| rsp_err | output | 1 | Access violation |
| ch_done | input | NCH | Per-channel completion pulse from the engines |
| ch_start | output | NCH | Per-channel launch pulse |
| ch_abort | output | NCH | Per-channel abort pulse |
| ch_src | output | 32*NCH | Source address per channel |
| ch_dst | output | 32*NCH | Destination address per channel |
| ch_len | output | 32*NCH | Byte count per channel |
| irq | output | NCH | Per-channel interrupt |

## Verification
The bound checker watches several rules on every cycle. It checks the one-cycle response timing and the error flag on misaligned offsets. It checks that error responses carry zero data and that at most one channel launches per cycle. It checks that a start pulse carries the word just written, with its low bits cleared, and that an interrupt is low while its channel aborts. The directed scenarios are needed for the history-dependent behaviour. That covers read-back after masking, writes ignored while busy or done, a count that reads zero after completion, mask toggling, the done-against-reset collision, and the fact that a rejected access leaves the registers untouched.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        SEL_SRC = 3'd0,
        SEL_DST = 3'd1,
        SEL_LEN = 3'd2,
        SEL_RST = 3'd3,
        SEL_DIS = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_BUSY = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    function automatic logic [WORD_W-1:0] word_align(input logic [WORD_W-1:0] v);
        return {v[WORD_W-1:2], 2'b00};
    endfunction
endpackage

// File: rtl/mdma_decode.sv
module mdma_decode
    import mdma_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [7:0] addr,
    input  logic       we,
    output logic       ok,
    output logic [2:0] ch_idx,
    output reg_sel_e   sel
);
    logic [2:0] reg_idx;

    always_comb begin
        reg_idx = addr[4:2];
        ch_idx  = addr[7:5];
        ok      = (addr[1:0] == 2'b00)
               && ({29'd0, ch_idx} < NCH)
               && (reg_idx <= 3'd4)
               && !(!we && reg_idx == 3'd3);
        sel     = ok ? reg_sel_e'(reg_idx) : SEL_SRC;
    end
endmodule

// File: rtl/mdma_chan.sv
module mdma_chan
    import mdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              done,
    output logic [WORD_W-1:0] src,
    output logic [WORD_W-1:0] dst,
    output logic [WORD_W-1:0] len,
    output logic [WORD_W-1:0] dis,
    output logic              start,
    output logic              abort,
    output logic              irq
);
    ch_state_e state, nxt;
    logic rst_wr, idle_wr, len_wr, finish;

    always_comb begin
        rst_wr  = wr_en && (sel == SEL_RST);
        idle_wr = wr_en && (state == CH_IDLE);
        len_wr  = idle_wr && (sel == SEL_LEN);
        finish  = (state == CH_BUSY) && done;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            CH_IDLE: if (len_wr) nxt = CH_BUSY;
            CH_BUSY: if (done)   nxt = CH_DONE;
            CH_DONE: nxt = CH_DONE;
            default: nxt = CH_IDLE;
        endcase
        if (rst_wr) nxt = CH_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt;
    end

    // register storage and output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src   <= '0;
            dst   <= '0;
            len   <= '0;
            dis   <= '0;
            start <= 1'b0;
            abort <= 1'b0;
        end else begin
            start <= len_wr && !rst_wr;
            abort <= rst_wr;
            if (idle_wr && sel == SEL_SRC) src <= word_align(wdata);
            if (idle_wr && sel == SEL_DST) dst <= word_align(wdata);
            if (wr_en && sel == SEL_DIS)   dis <= wdata;
            if (rst_wr || finish)          len <= '0;
            else if (len_wr)               len <= word_align(wdata);
        end
    end

    assign irq = (state == CH_DONE) && (dis == '0);
endmodule

// File: rtl/mdma_regs.sv
module mdma_regs
    import mdma_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [NCH-1:0]    ch_done,
    output logic [NCH-1:0]    ch_start,
    output logic [NCH-1:0]    ch_abort,
    output logic [32*NCH-1:0] ch_src,
    output logic [32*NCH-1:0] ch_dst,
    output logic [32*NCH-1:0] ch_len,
    output logic [NCH-1:0]    irq
);
    logic        dec_ok;
    logic [2:0]  dec_ch;
    reg_sel_e    dec_sel;
    logic [WORD_W-1:0] src_a [NCH];
    logic [WORD_W-1:0] dst_a [NCH];
    logic [WORD_W-1:0] len_a [NCH];
    logic [WORD_W-1:0] dis_a [NCH];
    logic [WORD_W-1:0] rd_mux;

    mdma_decode #(.NCH(NCH)) u_dec (
        .addr(req_addr), .we(req_we), .ok(dec_ok), .ch_idx(dec_ch), .sel(dec_sel)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic hit_wr;
        assign hit_wr = req_valid && req_we && dec_ok && (dec_ch == 3'(k));
        mdma_chan u_chan (
            .clk(clk), .rst_n(rst_n), .wr_en(hit_wr), .sel(dec_sel),
            .wdata(req_wdata), .done(ch_done[k]),
            .src(src_a[k]), .dst(dst_a[k]), .len(len_a[k]), .dis(dis_a[k]),
            .start(ch_start[k]), .abort(ch_abort[k]), .irq(irq[k])
        );
        assign ch_src[32*k +: 32] = src_a[k];
        assign ch_dst[32*k +: 32] = dst_a[k];
        assign ch_len[32*k +: 32] = len_a[k];
    end

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NCH; k++) begin
            if (dec_ch == 3'(k)) begin
                unique case (dec_sel)
                    SEL_SRC: rd_mux = src_a[k];
                    SEL_DST: rd_mux = dst_a[k];
                    SEL_LEN: rd_mux = len_a[k];
                    SEL_DIS: rd_mux = dis_a[k];
                    default: rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !dec_ok;
            rsp_rdata <= (req_valid && !req_we && dec_ok) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/mdma_regs_chk.sv
module mdma_regs_chk #(
    parameter int NCH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [7:0]        req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic [NCH-1:0]    ch_start,
    input logic [NCH-1:0]    ch_abort,
    input logic [32*NCH-1:0] ch_len,
    input logic [NCH-1:0]    irq
);
    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R8
    misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err);
    // R8
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'd0));
    // R3
    single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_start));

    for (genvar k = 0; k < NCH; k++) begin : g_k
        // R3
        start_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_start[k] |-> (ch_len[32*k +: 32] == {$past(req_wdata[31:2]), 2'b00}));
        // R3
        start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_start[k] |=> !ch_start[k]);
        // R7
        abort_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_abort[k] |-> !irq[k]);
    end
endmodule

bind mdma_regs mdma_regs_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .ch_start(ch_start), .ch_abort(ch_abort),
    .ch_len(ch_len), .irq(irq)
);

// File: tb/sim_mdma_regs.sv
module sim_mdma_regs;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [7:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [NCH-1:0] ch_done = '0;
    logic [NCH-1:0] ch_start, ch_abort, irq;
    logic [32*NCH-1:0] ch_src, ch_dst, ch_len;

    int n_chk = 0, n_err = 0;
    logic [31:0] r_data;
    logic r_err, r_valid;
    logic [NCH-1:0] r_start, r_abort;

    always #4 clk = ~clk;

    mdma_regs #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .ch_done(ch_done),
        .ch_start(ch_start), .ch_abort(ch_abort), .ch_src(ch_src),
        .ch_dst(ch_dst), .ch_len(ch_len), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [NCH-1:0] dn);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d; ch_done = dn;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0; ch_done = '0;
        r_valid = rsp_valid; r_err = rsp_err; r_start = ch_start; r_abort = ch_abort;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        r_valid = rsp_valid; r_err = rsp_err; r_data = rsp_rdata;
    endtask

    task automatic pulse_done(input logic [NCH-1:0] dn);
        @(negedge clk); ch_done = dn;
        @(negedge clk); ch_done = '0;
    endtask

    task automatic t_reset;
        chk("R9 irq", {28'd0, irq}, 32'd0);
        chk("R9 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R9 start/abort", {24'd0, ch_start, ch_abort}, 32'd0);
        rd(8'h00); chk("R9 src0", r_data, 32'd0);
        chk("R1 valid", {31'd0, r_valid}, 32'd1);
        rd(8'h70); chk("R9 mask3", r_data, 32'd0);
    endtask

    task automatic t_readback;
        wr(8'h20, 32'h1000_0003, '0); chk("R2 wr ok", {31'd0, r_err}, 32'd0);
        rd(8'h20); chk("R2 src1 masked", r_data, 32'h1000_0000);
        wr(8'h44, 32'hABCD_EF06, '0);
        rd(8'h44); chk("R2 dst2 masked", r_data, 32'hABCD_EF04);
        chk("R1 dst2 port", ch_dst[64 +: 32], 32'hABCD_EF04);
        wr(8'h30, 32'h0000_0005, '0);
        rd(8'h30); chk("R2 mask1 full", r_data, 32'h5);
        wr(8'h30, 32'h0, '0);
    endtask

    task automatic t_launch;
        wr(8'h00, 32'h0000_1000, '0);
        wr(8'h04, 32'h0000_2000, '0);
        wr(8'h08, 32'h0000_0041, '0);
        chk("R3 start", {28'd0, r_start}, 32'h1);
        chk("R3 ch_len", ch_len[31:0], 32'h40);
        @(negedge clk); chk("R3 pulse ends", {28'd0, ch_start}, 32'h0);
        rd(8'h08); chk("R3 len busy", r_data, 32'h40);
        wr(8'h00, 32'h0000_2222, '0);
        rd(8'h00); chk("R4 src busy kept", r_data, 32'h1000);
        wr(8'h08, 32'h0000_0080, '0);
        chk("R4 no restart busy", {28'd0, r_start}, 32'h0);
        rd(8'h08); chk("R4 len busy kept", r_data, 32'h40);
    endtask

    task automatic t_finish;
        pulse_done(4'b0001);
        rd(8'h08); chk("R5 len zero", r_data, 32'h0);
        chk("R6 irq on", {28'd0, irq}, 32'h1);
        wr(8'h10, 32'h0000_0100, '0);
        chk("R6 irq masked", {28'd0, irq}, 32'h0);
        wr(8'h10, 32'h0, '0);
        chk("R6 irq unmasked", {28'd0, irq}, 32'h1);
        wr(8'h08, 32'h0000_0010, '0);
        chk("R4 no start in done", {28'd0, r_start}, 32'h0);
        rd(8'h08); chk("R4 len done kept", r_data, 32'h0);
        wr(8'h0C, 32'hDEAD_BEEF, '0);
        chk("R7 abort", {28'd0, r_abort}, 32'h1);
        chk("R7 irq clear", {28'd0, irq}, 32'h0);
        rd(8'h00); chk("R7 src kept", r_data, 32'h1000);
        pulse_done(4'b0001);
        chk("R5 done idle ignored", {28'd0, irq}, 32'h0);
        wr(8'h08, 32'h0000_0008, '0);
        chk("R3 relaunch", {28'd0, r_start}, 32'h1);
        wr(8'h0C, 32'h0, '0);
        rd(8'h08); chk("R7 len cleared", r_data, 32'h0);
    endtask

    task automatic t_collide;
        wr(8'h48, 32'h0000_0100, '0);
        chk("R3 start ch2", {28'd0, r_start}, 32'h4);
        wr(8'h4C, 32'h1, 4'b0100);
        chk("R7 abort wins", {28'd0, r_abort}, 32'h4);
        chk("R7 no irq", {28'd0, irq}, 32'h0);
        rd(8'h48); chk("R7 len zero", r_data, 32'h0);
        wr(8'h70, 32'h1, '0);
        wr(8'h68, 32'h20, '0);
        pulse_done(4'b1000);
        chk("R6 masked at done", {28'd0, irq}, 32'h0);
        rd(8'h68); chk("R5 len3 zero", r_data, 32'h0);
        wr(8'h70, 32'h0, '0);
        chk("R6 late unmask", {28'd0, irq}, 32'h8);
        wr(8'h6C, 32'h0, '0);
    endtask

    task automatic t_errors;
        wr(8'h21, 32'hFFFF_FFF0, '0); chk("R8 misaligned err", {31'd0, r_err}, 32'h1);
        rd(8'h20); chk("R8 src1 untouched", r_data, 32'h1000_0000);
        rd(8'h80); chk("R8 chan4 err", {31'd0, r_err}, 32'h1);
        chk("R8 err data", r_data, 32'h0);
        wr(8'h34, 32'h1, '0); chk("R8 reg5 err", {31'd0, r_err}, 32'h1);
        rd(8'h1C); chk("R8 reg7 err", {31'd0, r_err}, 32'h1);
        rd(8'h2C); chk("R8 reset read err", {31'd0, r_err}, 32'h1);
        wr(8'hE8, 32'h40, '0);
        chk("R8 no start oob", {28'd0, r_start}, 32'h0);
        chk("R8 oob err", {31'd0, r_err}, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_launch();
        t_finish();
        t_collide();
        t_errors();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule